// File: doc/BRIEF.md
# Staged Pipeline Control Carrier

This block sits behind the decode stage of a five-stage load/store pipeline. It takes the control word that decode produces for one instruction and moves it down the pipeline one stage per clock, so that the control bits stay with their instruction. Each stage receives only the bits it acts on. Fetch and decode need no staged control, so the block has no outputs for them.

The word has three groups. The execute group holds a destination-register select, a 2-bit ALU operation code and a second-operand select, which picks the register value or the sign-extended immediate. The memory group holds a branch-if-equal flag, a load flag and a store flag. The write-back group holds a result-source select, which picks the ALU result or loaded data, and a register-write enable. The first pipeline register holds all three groups. The second holds memory and write-back. The third holds write-back only. Each group is dropped once its stage has used it.

A hazard unit raises `bubble` to send a do-nothing instruction into execute. Branch resolution raises `flush` to squash the two instructions that were fetched after a taken branch.

Top module: `ctl_stage_top`

## Requirements
- R1: The control word on `dec_ctl` is split as follows: bit 8 is the destination select, bits 7:6 are the ALU op, bit 5 is the operand select, bit 4 is branch-equal, bit 3 is load, bit 2 is store, bit 1 is the result-source select and bit 0 is register write. When neither `bubble` nor `flush` is high at a clock edge, the execute group of that word appears on the `ex_*` outputs in the next cycle.
- R2: The memory group of a word appears on `mem_br_eq`, `mem_rd` and `mem_wr` two cycles after the word was taken in, unless a bubble or flush removed it.
- R3: The write-back group of a word appears on `wb_from_mem` and `wb_reg_wr` three cycles after the word was taken in, unless a bubble or flush removed it.
- R4: When `bubble` is high at an edge, every bit entering the first stage is cleared. That instruction then shows all-zero execute, memory and write-back outputs in the following three cycles.
- R5: When `flush` is high at an edge, the word entering the first stage is cleared. The memory and write-back bits of the instruction then in execute are also cleared. The instruction already in the memory stage goes on to write-back unchanged.
- R6: A synchronous active-high `rst` clears every staged bit, so that all outputs read zero in the cycle after the reset edge.
- R7: Back-to-back instructions each keep their own control bits. No stage mixes bits from two different words.
- R8: The ALU op passes through unchanged for all four codes: 00 is add, 01 is subtract for a branch compare, 10 is decode by function field, and 11 is carried as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_ctl | input | 9 | Control word from decode |
| bubble | input | 1 | Insert a do-nothing instruction into execute |
| flush | input | 1 | Squash the instructions in decode and execute |
| ex_dst_sel | output | 1 | Destination register select |
| ex_alu_op | output | 2 | ALU operation code |
| ex_opb_imm | output | 1 | Second operand is the immediate |
| mem_br_eq | output | 1 | Branch if equal |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| wb_from_mem | output | 1 | Write back loaded data instead of the ALU result |
| wb_reg_wr | output | 1 | Register file write enable |

## Verification
Random control words that change every cycle show whether each group lands exactly one, two or three cycles later. Such words also show whether bits from neighbouring instructions get mixed. Isolated bubbles and flushes, driven both alone and on the same edge, separate the cleared first-stage entry from the partial clear of execute. A flush must leave the memory-stage instruction untouched, so the bench checks that case on its own. A sweep over the four ALU op codes, and a reset applied in the middle of traffic, cover the remaining edges.

// File: rtl/ctl_stage_pkg.sv
package ctl_stage_pkg;
  localparam int ALUOP_W = 2;

  typedef struct packed {
    logic               dst_sel;
    logic [ALUOP_W-1:0] alu_op;
    logic               opb_imm;
  } ex_grp_t;

  typedef struct packed {
    logic br_eq;
    logic mem_rd;
    logic mem_wr;
  } mem_grp_t;

  typedef struct packed {
    logic wb_from_mem;
    logic reg_wr;
  } wb_grp_t;

  typedef struct packed {
    ex_grp_t  ex;
    mem_grp_t mem;
    wb_grp_t  wb;
  } ctl_word_t;

  typedef struct packed {
    mem_grp_t mem;
    wb_grp_t  wb;
  } late_grp_t;

  localparam int EX_W   = $bits(ex_grp_t);
  localparam int MEM_W  = $bits(mem_grp_t);
  localparam int WB_W   = $bits(wb_grp_t);
  localparam int LATE_W = MEM_W + WB_W;
  localparam int CW     = EX_W + LATE_W;

  function automatic late_grp_t drop_ex(ctl_word_t w);
    late_grp_t r;
    r.mem = w.mem;
    r.wb  = w.wb;
    return r;
  endfunction

  function automatic wb_grp_t drop_mem(late_grp_t w);
    return w.wb;
  endfunction
endpackage

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         kill,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || kill) q <= '0;
    else             q <= d;
  end
endmodule

// File: rtl/ctl_stage_top.sv
module ctl_stage_top
  import ctl_stage_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CW-1:0]      dec_ctl,
  input  logic               bubble,
  input  logic               flush,
  output logic               ex_dst_sel,
  output logic [ALUOP_W-1:0] ex_alu_op,
  output logic               ex_opb_imm,
  output logic               mem_br_eq,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               wb_from_mem,
  output logic               wb_reg_wr
);
  ctl_word_t dec_w;
  ctl_word_t idex_q;
  late_grp_t exmem_d, exmem_q;
  wb_grp_t   memwb_d, memwb_q;

  logic      idex_kill;
  logic      exmem_kill;
  mem_grp_t  idex_mem;
  wb_grp_t   idex_wb;
  wb_grp_t   exmem_wb;

  assign dec_w      = ctl_word_t'(dec_ctl);
  assign idex_kill  = bubble | flush;
  assign exmem_kill = flush;

  ctl_stage_reg #(.W(CW)) u_idex (
    .clk(clk), .rst(rst), .kill(idex_kill), .d(dec_w), .q(idex_q)
  );

  assign exmem_d = drop_ex(idex_q);

  ctl_stage_reg #(.W(LATE_W)) u_exmem (
    .clk(clk), .rst(rst), .kill(exmem_kill), .d(exmem_d), .q(exmem_q)
  );

  assign memwb_d = drop_mem(exmem_q);

  ctl_stage_reg #(.W(WB_W)) u_memwb (
    .clk(clk), .rst(rst), .kill(1'b0), .d(memwb_d), .q(memwb_q)
  );

  assign idex_mem = idex_q.mem;
  assign idex_wb  = idex_q.wb;
  assign exmem_wb = exmem_q.wb;

  assign ex_dst_sel  = idex_q.ex.dst_sel;
  assign ex_alu_op   = idex_q.ex.alu_op;
  assign ex_opb_imm  = idex_q.ex.opb_imm;
  assign mem_br_eq   = exmem_q.mem.br_eq;
  assign mem_rd      = exmem_q.mem.mem_rd;
  assign mem_wr      = exmem_q.mem.mem_wr;
  assign wb_from_mem = memwb_q.wb_from_mem;
  assign wb_reg_wr   = memwb_q.reg_wr;
endmodule

// File: rtl/ctl_stage_chk.sv
module ctl_stage_chk
  import ctl_stage_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [CW-1:0]      dec_ctl,
  input logic               bubble,
  input logic               flush,
  input logic               ex_dst_sel,
  input logic [ALUOP_W-1:0] ex_alu_op,
  input logic               ex_opb_imm,
  input logic               mem_br_eq,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic               wb_from_mem,
  input logic               wb_reg_wr,
  input mem_grp_t           idex_mem,
  input wb_grp_t            idex_wb,
  input wb_grp_t            exmem_wb
);
  a_r1_ex_next: assert property (@(posedge clk) disable iff (rst)
    (!bubble && !flush) |=> {ex_dst_sel, ex_alu_op, ex_opb_imm} == $past(dec_ctl[CW-1:LATE_W]));

  a_r2_mem_follows: assert property (@(posedge clk) disable iff (rst)
    !flush |=> {mem_br_eq, mem_rd, mem_wr} == $past(idex_mem));

  a_r3_wb_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> {wb_from_mem, wb_reg_wr} == $past(exmem_wb));

  a_r4_bubble_clears: assert property (@(posedge clk) disable iff (rst)
    bubble |=> ({ex_dst_sel, ex_alu_op, ex_opb_imm} == '0 && idex_mem == '0 && idex_wb == '0));

  a_r5_flush_squash: assert property (@(posedge clk) disable iff (rst)
    flush |=> ({mem_br_eq, mem_rd, mem_wr} == '0 && exmem_wb == '0 && idex_wb == '0));

  a_r6_reset_zero: assert property (@(posedge clk)
    rst |=> ({ex_dst_sel, ex_alu_op, ex_opb_imm, mem_br_eq, mem_rd, mem_wr,
              wb_from_mem, wb_reg_wr} == '0));
endmodule

bind ctl_stage_top ctl_stage_chk u_chk (.*);

// File: tb/test_ctl_stage_top.sv
module test_ctl_stage_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [8:0] dec_ctl;
  logic       bubble, flush;
  logic       ex_dst_sel, ex_opb_imm, mem_br_eq, mem_rd, mem_wr, wb_from_mem, wb_reg_wr;
  logic [1:0] ex_alu_op;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [8:0] m_idex;
  logic [4:0] m_exmem;
  logic [1:0] m_memwb;

  always #2 clk = ~clk;

  ctl_stage_top i_ctl_stage_top (
    .clk(clk), .rst(rst), .dec_ctl(dec_ctl), .bubble(bubble), .flush(flush),
    .ex_dst_sel(ex_dst_sel), .ex_alu_op(ex_alu_op), .ex_opb_imm(ex_opb_imm),
    .mem_br_eq(mem_br_eq), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .wb_from_mem(wb_from_mem), .wb_reg_wr(wb_reg_wr)
  );

  function automatic logic [3:0] want_ex(logic [8:0] w);
    return {w[8], w[7:6], w[5]};
  endfunction
  function automatic logic [4:0] late_part(logic [8:0] w);
    return w[4:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_idex <= '0; m_exmem <= '0; m_memwb <= '0;
    end else begin
      m_memwb <= m_exmem[1:0];
      m_exmem <= flush ? 5'd0 : late_part(m_idex);
      m_idex  <= (bubble || flush) ? 9'd0 : dec_ctl;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " ex"},  {28'd0, ex_dst_sel, ex_alu_op, ex_opb_imm}, {28'd0, want_ex(m_idex)});
    check({tag, " mem"}, {29'd0, mem_br_eq, mem_rd, mem_wr}, {29'd0, m_exmem[4:2]});
    check({tag, " wb"},  {30'd0, wb_from_mem, wb_reg_wr}, {30'd0, m_memwb});
  endtask

  task automatic step(logic [8:0] w, logic b, logic f);
    dec_ctl = w; bubble = b; flush = f;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_c7a1));
    rst = 1'b1; dec_ctl = '0; bubble = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R6 reset");
    rst = 1'b0;

    // R1 R2 R3: one word followed by zeros
    step(9'h1ff, 0, 0);
    check({"R1 ex delay"}, {28'd0, ex_dst_sel, ex_alu_op, ex_opb_imm}, 32'hf);
    step(9'h000, 0, 0);
    check("R2 mem delay", {29'd0, mem_br_eq, mem_rd, mem_wr}, 32'h7);
    step(9'h000, 0, 0);
    check("R3 wb delay", {30'd0, wb_from_mem, wb_reg_wr}, 32'h3);

    // R8: ALU op codes
    for (int k = 0; k < 4; k++) begin
      step({1'b0, k[1:0], 6'd0}, 0, 0);
      check("R8 alu op", {30'd0, ex_alu_op}, k);
    end

    // R4: bubble on a full word
    step(9'h1ff, 1, 0);
    check_all("R4 bubble");
    step(9'h000, 0, 0); check_all("R4 bubble");
    step(9'h000, 0, 0); check_all("R4 bubble");
    check("R4 no reg write", {31'd0, wb_reg_wr}, 32'd0);

    // R5: flush with live words in every stage
    step(9'h01b, 0, 0);
    step(9'h016, 0, 0);
    step(9'h1ff, 1, 1);
    check_all("R5 flush");
    check("R5 mem stage kept", {30'd0, wb_from_mem, wb_reg_wr}, 32'h3);
    check("R5 exec squashed", {29'd0, mem_br_eq, mem_rd, mem_wr}, 32'd0);
    step(9'h000, 0, 0); check_all("R5 flush");
    step(9'h000, 0, 0); check_all("R5 flush");

    // R7 with R1 R2 R3: random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[8:0], r[12:10] == 3'd0, r[16:13] == 4'd0);
      check_all("R7 random");
    end

    // R6: reset in the middle of traffic
    step(9'h1ff, 0, 0);
    rst = 1'b1;
    step(9'h1ff, 0, 0);
    check_all("R6 mid reset");
    check("R6 all zero", {23'd0, ex_dst_sel, ex_alu_op, ex_opb_imm, mem_br_eq, mem_rd,
                          mem_wr, wb_from_mem, wb_reg_wr}, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule